// File: doc/BRIEF.md
# CAM Host Cycle Front End and Match-Flag Chain

This block sits between a host bus and a cascadable content-addressable memory. The host runs strobed cycles with an active-low enable, `en_ni`. The block samples that enable on the system clock. When the enable falls, the block latches the write, command-select and chain-enable controls and decodes which of four cycle types is running. When the enable rises, it releases the data bus, steps the segment pointers on data cycles and locks a new value onto the active-low match flag.

The match flag can be cascaded. Each device passes a match from a higher-priority neighbour, received on `mi_ni`, down to its own flag output. It adds its own local match result only when the control register allows matching. The flag takes part in the chain only when chain-enable was LOW at the enable falling edge that opened the cycle. It is forced HIGH by a switch of the active configuration set and by reset.

Enable edges are seen three clock edges after the pin changes. Two of these edges are the synchronizer and one is the capture register. All responses are timed from that point.

Top module: `cam_cycle_ctrl`

## Requirements
- R1: While reset is held and right after it: `mf_no` is 1, `dq_oe_o` is 0, `cycle_active_o` is 0, and both segment counters are 0.
- R2: On the third rising clock edge after `en_ni` falls, `cycle_active_o` becomes 1. `cycle_o` then shows {wr_ni, cmd_ni} as latched: 00 is command write, 01 is data write, 10 is command read, 11 is data read. On the third rising clock edge after `en_ni` rises, `cycle_active_o` returns to 0.
- R3: `dq_oe_o` is 1 only while a cycle is active and `cycle_o[1]` is 1 (a read). `dq_o` then equals `rd_data_i`. At all other times `dq_o` is 0 and the bus is released.
- R4: Changes on `wr_ni`, `cmd_ni` and `chain_ni` while a cycle is active do not alter `cycle_o` or `dq_oe_o`.
- R5: When a data cycle ends (`cycle_o[0]`=1), `dst_seg_o` and `src_seg_o` each advance by one. When a command cycle ends, both stay unchanged.
- R6: The segment counters are SEG_W bits wide (2 by default) and wrap from their maximum value to 0.
- R7: If chain-enable was LOW at the opening edge and `match_en_i` is 1, then at the end of the cycle `mf_no` becomes 0 when `mi_ni` is 0 or `match_local_i` is 1. Otherwise it becomes 1.
- R8: If chain-enable was LOW at the opening edge and `match_en_i` is 0, then at the end of the cycle `mf_no` takes the value of `mi_ni`, and `match_local_i` has no effect.
- R9: If chain-enable was HIGH at the opening edge, then at the end of the cycle `mf_no` becomes 1, whatever the match inputs are.
- R10: `mf_no` changes only at the end of a cycle, on a configuration switch, or on reset. Between those events it holds its value.
- R11: A 1 on `cfg_switch_i` at a rising clock edge sets `mf_no` to 1 from that edge onward.
- R12: Asserting `rst_ni` at any time forces `mf_no` to 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Host cycle enable, active low, asynchronous to clk_i |
| wr_ni | input | 1 | Direction: 0 write, 1 read |
| cmd_ni | input | 1 | Kind: 0 command, 1 data |
| chain_ni | input | 1 | Chain/flag enable, active low |
| rd_data_i | input | DW | Read data to place on the bus |
| match_local_i | input | 1 | Local valid match result |
| match_en_i | input | 1 | Control-register match enable |
| mi_ni | input | 1 | Upstream match input, active low |
| cfg_switch_i | input | 1 | Pulse: active configuration set switched |
| dq_o | output | DW | Bus data out |
| dq_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| cycle_o | output | 2 | Latched cycle type {wr, cmd} |
| cycle_active_o | output | 1 | A host cycle is open |
| mf_no | output | 1 | Match flag, active low |
| dst_seg_o | output | SEG_W | Destination segment counter |
| src_seg_o | output | SEG_W | Source segment counter |

## Verification
The decode is driven through all four control combinations. This separates a swapped direction bit from a swapped kind bit, and shows that bus drive follows only the read kinds. The flag is tried with the upstream input and the local match each set alone and both clear. This is done under match-enabled, match-disabled and chain-disabled settings, so the OR term, the pass-through and the force-high are each seen on their own. Runs of data cycles mixed with command cycles show a counter that steps on the wrong kind or fails to wrap. Changing the controls mid-cycle, changing the match inputs between cycles, and pulsing the configuration switch show whether the latched state is really held.

// File: rtl/cam_cyc_pkg.sv
package cam_cyc_pkg;
  typedef enum logic [1:0] {
    CYC_CMD_WR  = 2'b00,
    CYC_DATA_WR = 2'b01,
    CYC_CMD_RD  = 2'b10,
    CYC_DATA_RD = 2'b11
  } cyc_e;

  function automatic logic is_read(cyc_e c);
    return c[1];
  endfunction

  function automatic logic is_data(cyc_e c);
    return c[0];
  endfunction
endpackage

// File: rtl/cam_edge_sync.sv
module cam_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic fall_o,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], en_ni};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_N-1];
  assign rise_o = ~prev_q & sync_q[SYNC_N-1];

  p_edge_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_o && rise_o));
endmodule

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
  import cam_cyc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic rise_i,
  input  logic wr_ni,
  input  logic cmd_ni,
  input  logic chain_ni,
  output logic active_o,
  output cyc_e cyc_o,
  output logic chain_en_o,
  output logic read_o,
  output logic data_end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      cyc_o      <= CYC_CMD_WR;
      chain_en_o <= 1'b0;
    end else if (fall_i) begin
      active_o   <= 1'b1;
      cyc_o      <= cyc_e'({wr_ni, cmd_ni});
      chain_en_o <= ~chain_ni;
    end else if (rise_i) begin
      active_o   <= 1'b0;
    end
  end

  assign read_o     = active_o & is_read(cyc_o);
  assign data_end_o = rise_i & active_o & is_data(cyc_o);

  p_cyc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !fall_i) |=> ($stable(cyc_o) && $stable(chain_en_o)));
  p_idle_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !read_o);
endmodule

// File: rtl/cam_seg_counter.sv
module cam_seg_counter #(
  parameter int SEG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [SEG_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end

  p_seg_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_o == SEG_W'($past(cnt_o) + 1'b1));
  p_seg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_o));
  p_seg_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_o == '1) |=> cnt_o == '0);
endmodule

// File: rtl/cam_match_chain.sv
module cam_match_chain (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic chain_en_i,
  input  logic mi_ni,
  input  logic match_local_i,
  input  logic match_en_i,
  input  logic cfg_switch_i,
  output logic mf_no
);
  logic hit;
  assign hit = ~mi_ni | (match_en_i & match_local_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mf_no <= 1'b1;
    else if (cfg_switch_i) mf_no <= 1'b1;
    else if (lock_i)       mf_no <= ~(chain_en_i & hit);
  end

  p_mf_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !chain_en_i) |=> mf_no);
  p_mf_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && chain_en_i && !match_en_i && !cfg_switch_i) |=> mf_no == $past(mi_ni));
  p_mf_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !cfg_switch_i) |=> $stable(mf_no));
  p_mf_cfg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_switch_i |=> mf_no);
endmodule

// File: rtl/cam_cycle_ctrl.sv
module cam_cycle_ctrl
  import cam_cyc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SEG_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic             wr_ni,
  input  logic             cmd_ni,
  input  logic             chain_ni,
  input  logic [DW-1:0]    rd_data_i,
  input  logic             match_local_i,
  input  logic             match_en_i,
  input  logic             mi_ni,
  input  logic             cfg_switch_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o,
  output logic [1:0]       cycle_o,
  output logic             cycle_active_o,
  output logic             mf_no,
  output logic [SEG_W-1:0] dst_seg_o,
  output logic [SEG_W-1:0] src_seg_o
);
  localparam int NSEG = 2;

  logic fall, rise, active, chain_en, rd, data_end;
  cyc_e cyc;
  logic [SEG_W-1:0] seg [NSEG];

  cam_edge_sync #(.SYNC_N(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .en_ni, .fall_o(fall), .rise_o(rise)
  );

  cam_cycle_decode i_dec (
    .clk_i, .rst_ni, .fall_i(fall), .rise_i(rise),
    .wr_ni, .cmd_ni, .chain_ni,
    .active_o(active), .cyc_o(cyc), .chain_en_o(chain_en),
    .read_o(rd), .data_end_o(data_end)
  );

  // index 0: destination, index 1: source
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    cam_seg_counter #(.SEG_W(SEG_W)) i_cnt (
      .clk_i, .rst_ni, .step_i(data_end), .cnt_o(seg[g])
    );
  end

  // chain state locks on the closing edge of an open cycle
  cam_match_chain i_mf (
    .clk_i, .rst_ni, .lock_i(rise & active), .chain_en_i(chain_en),
    .mi_ni, .match_local_i, .match_en_i, .cfg_switch_i, .mf_no
  );

  assign dq_oe_o        = rd;
  assign dq_o           = rd ? rd_data_i : '0;
  assign cycle_o        = cyc;
  assign cycle_active_o = active;
  assign dst_seg_o      = seg[0];
  assign src_seg_o      = seg[1];

  p_bus_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_active_o |-> (!dq_oe_o && dq_o == '0));
  p_bus_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (cycle_o[1] && cycle_active_o));
  p_seg_lockstep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_seg_o == src_seg_o);
endmodule

// File: tb/test_cam_cycle_ctrl.sv
module test_cam_cycle_ctrl;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int SEG_W = 2;

  logic clk = 0, rst_ni = 0;
  logic en_ni = 1, wr_ni = 1, cmd_ni = 1, chain_ni = 1;
  logic [DW-1:0] rd_data_i = 32'hA5C3_0F96;
  logic match_local_i = 0, match_en_i = 0, mi_ni = 1, cfg_switch_i = 0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o, cycle_active_o, mf_no;
  logic [1:0] cycle_o;
  logic [SEG_W-1:0] dst_seg_o, src_seg_o;

  int checks = 0, fails = 0;
  logic [SEG_W-1:0] seg_exp = '0;
  logic cur_data = 0;

  always #(CLK_P/2) clk = ~clk;

  cam_cycle_ctrl #(.DW(DW), .SEG_W(SEG_W)) i_cam_cycle_ctrl (
    .clk_i(clk), .rst_ni, .en_ni, .wr_ni, .cmd_ni, .chain_ni, .rd_data_i,
    .match_local_i, .match_en_i, .mi_ni, .cfg_switch_i, .dq_o, .dq_oe_o,
    .cycle_o, .cycle_active_o, .mf_no, .dst_seg_o, .src_seg_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic open_cyc(logic w, logic c, logic ch);
    @(negedge clk);
    wr_ni = w; cmd_ni = c; chain_ni = ch; cur_data = c;
    @(negedge clk);
    en_ni = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_cyc();
    en_ni = 1;
    repeat (3) @(negedge clk);
    if (cur_data) seg_exp = seg_exp + 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 mf", mf_no, 1);
    chk("R1 oe", dq_oe_o, 0);
    chk("R1 active", cycle_active_o, 0);
    chk("R1 seg", {dst_seg_o, src_seg_o}, 0);
    chk("R1 dq", dq_o, 0);
  endtask

  task automatic t_decode();
    for (int k = 0; k < 4; k++) begin
      logic [1:0] t = 2'(k);
      open_cyc(t[1], t[0], 1);
      chk("R2 active", cycle_active_o, 1);
      chk("R2 type", cycle_o, t);
      chk("R3 oe", dq_oe_o, t[1]);
      chk("R3 dq", dq_o, t[1] ? rd_data_i : 0);
      close_cyc();
      chk("R2 idle", cycle_active_o, 0);
      chk("R3 release", dq_oe_o, 0);
      chk("R5 dst", dst_seg_o, seg_exp);
      chk("R5 src", src_seg_o, seg_exp);
    end
  endtask

  task automatic t_ignore();
    open_cyc(0, 0, 1);
    wr_ni = 1; cmd_ni = 1; chain_ni = 0;
    repeat (3) @(negedge clk);
    chk("R4 type", cycle_o, 2'b00);
    chk("R4 oe", dq_oe_o, 0);
    mi_ni = 0;
    close_cyc();
    chk("R4 chain", mf_no, 1);
    chk("R5 cmd hold", dst_seg_o, seg_exp);
    mi_ni = 1;
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 6; k++) begin
      open_cyc(k[0], 1, 1);
      close_cyc();
      chk("R6 dst", dst_seg_o, seg_exp);
      chk("R6 src", src_seg_o, seg_exp);
    end
  endtask

  task automatic match_case(string req, logic ch, logic en, logic mi, logic loc, logic exp);
    open_cyc(0, 0, ch);
    match_en_i = en; mi_ni = mi; match_local_i = loc;
    close_cyc();
    chk(req, mf_no, exp);
  endtask

  task automatic t_match();
    match_case("R7 local", 0, 1, 1, 1, 0);
    match_case("R7 none", 0, 1, 1, 0, 1);
    match_case("R7 upstream", 0, 1, 0, 0, 0);
    match_case("R8 local ignored", 0, 0, 1, 1, 1);
    match_case("R8 follow mi", 0, 0, 0, 1, 0);
    match_case("R9 chain off", 1, 1, 0, 1, 1);
    match_case("R9 chain off mi", 1, 0, 0, 0, 1);
  endtask

  task automatic t_hold();
    match_case("R7 set low", 0, 1, 0, 0, 0);
    mi_ni = 1; match_local_i = 0;
    repeat (5) @(negedge clk);
    chk("R10 idle hold", mf_no, 0);
    open_cyc(0, 1, 1);
    chk("R10 open hold", mf_no, 0);
    close_cyc();
    chk("R9 after close", mf_no, 1);
  endtask

  task automatic t_cfg();
    match_case("R7 pre cfg", 0, 1, 1, 1, 0);
    cfg_switch_i = 1;
    @(negedge clk);
    cfg_switch_i = 0;
    chk("R11 cfg", mf_no, 1);
    repeat (2) @(negedge clk);
    chk("R11 stays", mf_no, 1);
  endtask

  task automatic t_rst_mid();
    match_case("R7 pre rst", 0, 1, 0, 0, 0);
    #1 rst_ni = 0;
    #1 chk("R12 mf", mf_no, 1);
    chk("R12 seg", dst_seg_o, 0);
    @(negedge clk);
    rst_ni = 1;
    seg_exp = '0;
    mi_ni = 1;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_ignore();
    t_wrap();
    t_match();
    t_hold();
    t_cfg();
    t_rst_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule